// File: doc/BRIEF.md
# Half-Band Rate-Change Filter with Phase Alignment

This block is a fixed-coefficient, linear-phase, half-band low-pass FIR filter. It runs from one master clock, and that clock always runs at the faster of the input and output sample rates. A static mode selects one of four behaviours:

- 1:2 interpolation: the filter takes a sample on every second edge and feeds a zero sample on the edges between.
- 2:1 decimation: the output register updates on every second edge only.
- Equal-rate low-pass filtering.
- Plain delay with no filtering.

A synchronisation strobe fixes which edges are the sample edges. Without the strobe, a free-running phase toggle still alternates, but its alignment is not known to the host.

The input is a 12-bit two's-complement sample. The output is a wide, unrounded two's-complement result, scaled so that a value of `x·2^15` stands for input value `x`. A separate rounding and formatting stage is expected downstream. From input to output peak the group delay is a fixed 34 clocks. For interpolation and decimation, an optional double-latency setting makes it 68 clocks, so that a full-rate path can be matched to half-rate paths.

Top module: `hbf_filter`

## Requirements
- R1: `mode_i` selects the behaviour: 0 is equal-rate low-pass, 1 is 2:1 decimate, 2 is 1:2 interpolate, 3 is delay-only. `mode_i`, `half_gain_i` and `dbl_lat_i` are static during operation.
- R2: In interpolate mode, `din_i` reaches the filter only on accept edges. On all other edges a zero sample enters the filter instead. Accept edges and zero edges alternate.
- R3: An edge is an accept edge in two cases: `sync_i` is low at that edge and was high at the previous edge, or the previous edge was not an accept edge. Holding `sync_i` low, or toggling it every clock, keeps the alternation unchanged.
- R4: In decimate mode, `dout_o` takes a new value only on edges that are not accept edges. On accept edges it keeps its previous value.
- R5: In equal-rate and delay-only modes, `dout_o` updates on every edge, every input sample is used, and `sync_i` has no effect on the output.
- R6: An impulse applied at edge k first changes `dout_o` after edge k+15. The peak appears after edge k+34. The last nonzero value appears after edge k+53.
- R7: The kernel has 39 symmetric taps: a centre of 16384, zero at every even offset, and these values at odd offsets 1, 3, …, 19: 10346, −3240, 1720, −1030, 640, −390, 230, −120, 60, −24. `dout_o` is the full-precision sum of taps times samples.
- R8: In delay-only mode, `dout_o` after edge k+34 equals the sample taken at edge k times 2^15.
- R9: With `dbl_lat_i`=1, interpolate and decimate modes get 34 extra clocks of delay, for a total group delay of 68. In equal-rate and delay-only modes, `dbl_lat_i` has no effect.
- R10: Synchronous active-high reset clears `dout_o` and all filter history. After reset, the first edge with no sync fall is not an accept edge.
- R11: In interpolate mode with `half_gain_i`=0, the filter sum is doubled. With `half_gain_i`=1 it is not doubled. A constant input x therefore settles to `x·2^15` in every mode except halved interpolation, which settles to `x·2^14`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Behaviour select (R1 encoding) |
| half_gain_i | input | 1 | Interpolate without output doubling |
| dbl_lat_i | input | 1 | Add 34 clocks in interpolate/decimate |
| sync_i | input | 1 | Phase strobe; a falling edge marks an accept edge |
| din_i | input | 12 | Two's-complement input sample |
| dout_o | output | 30 | Unrounded two's-complement filter result |

## Verification
On every cycle, the embedded assertions check the following:
- the zero-stuffing of the filter input during interpolation;
- the strict alternation of accept edges;
- the forced realignment on a sync fall;
- the held output on accept edges during decimation.

Some behaviours only the bench's scenarios can show. These are the impulse timing at 15, 34 and 53 clocks, the exact kernel values, unity or halved DC gain per mode, the 68-clock double-latency path, and the indifference of the equal-rate and delay-only modes to the strobe. The bench compares every output against a cycle-accurate reference model.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    // Kernel geometry: 39 taps, centre index 19, ten odd-offset side taps
    localparam int NTAPS      = 39;
    localparam int CENTER     = (NTAPS - 1) / 2;
    localparam int NSIDE      = (CENTER + 1) / 2;
    localparam int COEF_FRAC  = 15;               // taps sum to 2**COEF_FRAC
    localparam int COEF_W     = COEF_FRAC + 1;
    localparam int GROUP_DLY  = 34;               // input edge to output peak
    // registers between tap 0 and output: pre-add, product, sum, pad, output
    localparam int PAD_STAGES = GROUP_DLY - CENTER - 4;

    typedef enum logic [1:0] {
        HB_EQUAL  = 2'd0,
        HB_DECIM  = 2'd1,
        HB_INTERP = 2'd2,
        HB_BYPASS = 2'd3
    } hb_mode_e;

    typedef struct packed {
        logic accept;   // this edge takes data (interp) / holds output (decim)
        logic restart;  // phase forced by a sync fall on this edge
    } hb_phase_t;

    // side tap at offset 2*s+1 from the centre
    function automatic int side_coef(input int s);
        case (s)
            0:       return 10346;
            1:       return -3240;
            2:       return 1720;
            3:       return -1030;
            4:       return 640;
            5:       return -390;
            6:       return 230;
            7:       return -120;
            8:       return 60;
            default: return -24;
        endcase
    endfunction

endpackage

// File: rtl/hbf_phase.sv
module hbf_phase
    import hbf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_i,
    output hb_phase_t ph_o
);

    logic sync_q;
    logic last_acc_q;

    always_comb begin
        ph_o.restart = sync_q && !sync_i;
        ph_o.accept  = ph_o.restart ? 1'b1 : !last_acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= 1'b0;
            last_acc_q <= 1'b1;
        end else begin
            sync_q     <= sync_i;
            last_acc_q <= ph_o.accept;
        end
    end

endmodule

// File: rtl/hbf_delay.sv
module hbf_delay #(
    parameter int W     = 30,
    parameter int DEPTH = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= d_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/hbf_core.sv
module hbf_core
    import hbf_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int ACC_W = 30
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bypass_i,
    input  logic signed [IN_W-1:0]  sample_i,
    output logic signed [IN_W-1:0]  tap0_o,
    output logic signed [ACC_W-1:0] acc_o
);

    localparam int PRE_W  = IN_W + 1;
    localparam int PROD_W = PRE_W + COEF_W - 1 + 1;

    logic signed [IN_W-1:0]   tap_q [NTAPS];
    logic signed [PRE_W-1:0]  pre_q [NSIDE];
    logic signed [PROD_W-1:0] prod_q [NSIDE];
    logic signed [IN_W-1:0]   mid_q;
    logic signed [IN_W-1:0]   mid2_q;
    logic signed [ACC_W-1:0]  mid_ext;
    logic signed [ACC_W-1:0]  sum_c;
    logic signed [ACC_W-1:0]  acc_q;

    // sample history, newest in tap 0
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAPS; i++) tap_q[i] <= '0;
        end else begin
            tap_q[0] <= sample_i;
            for (int i = 1; i < NTAPS; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    // symmetric pre-add, then constant multiply; even offsets are skipped
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSIDE; s++) begin
                pre_q[s]  <= '0;
                prod_q[s] <= '0;
            end
            mid_q  <= '0;
            mid2_q <= '0;
        end else begin
            for (int s = 0; s < NSIDE; s++) begin
                pre_q[s]  <= PRE_W'(tap_q[CENTER-1-2*s]) + PRE_W'(tap_q[CENTER+1+2*s]);
                prod_q[s] <= PROD_W'(pre_q[s]) * PROD_W'(side_coef(s));
            end
            mid_q  <= tap_q[CENTER];
            mid2_q <= mid_q;
        end
    end

    always_comb begin
        mid_ext = ACC_W'(mid2_q);
        sum_c   = mid_ext <<< (COEF_FRAC - 1);     // centre tap is one half
        for (int s = 0; s < NSIDE; s++) sum_c = sum_c + ACC_W'(prod_q[s]);
    end

    always_ff @(posedge clk) begin
        if (rst)           acc_q <= '0;
        else if (bypass_i) acc_q <= mid_ext <<< COEF_FRAC;
        else               acc_q <= sum_c;
    end

    assign tap0_o = tap_q[0];
    assign acc_o  = acc_q;

endmodule

// File: rtl/hbf_filter.sv
module hbf_filter
    import hbf_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = IN_W + hbf_pkg::COEF_FRAC + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              mode_i,
    input  logic                    half_gain_i,
    input  logic                    dbl_lat_i,
    input  logic                    sync_i,
    input  logic signed [IN_W-1:0]  din_i,
    output logic signed [OUT_W-1:0] dout_o
);

    hb_mode_e                mode;
    hb_phase_t               ph;
    logic                    is_interp;
    logic                    is_decim;
    logic signed [IN_W-1:0]  sample;
    logic signed [IN_W-1:0]  tap0;
    logic signed [OUT_W-1:0] acc;
    logic signed [OUT_W-1:0] pad_q;
    logic signed [OUT_W-1:0] long_q;
    logic signed [OUT_W-1:0] sel;
    logic signed [OUT_W-1:0] gained;
    logic signed [OUT_W-1:0] dout_q;
    logic                    live_q;

    assign mode      = hb_mode_e'(mode_i);
    assign is_interp = (mode == HB_INTERP);
    assign is_decim  = (mode == HB_DECIM);

    hbf_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_i),
        .ph_o   (ph)
    );

    // zero stuffing on the non-accept edges of interpolation
    assign sample = (is_interp && !ph.accept) ? '0 : din_i;

    hbf_core #(.IN_W(IN_W), .ACC_W(OUT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .bypass_i (mode == HB_BYPASS),
        .sample_i (sample),
        .tap0_o   (tap0),
        .acc_o    (acc)
    );

    hbf_delay #(.W(OUT_W), .DEPTH(PAD_STAGES)) u_pad (
        .clk (clk),
        .rst (rst),
        .d_i (acc),
        .q_o (pad_q)
    );

    hbf_delay #(.W(OUT_W), .DEPTH(GROUP_DLY)) u_long (
        .clk (clk),
        .rst (rst),
        .d_i (pad_q),
        .q_o (long_q)
    );

    assign sel    = (dbl_lat_i && (is_interp || is_decim)) ? long_q : pad_q;
    assign gained = (is_interp && !half_gain_i) ? (sel <<< 1) : sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
            if (!(is_decim && ph.accept)) dout_q <= gained;
        end
    end

    assign dout_o = dout_q;

    // a zero-phase edge in interpolation puts a zero sample into the kernel
    assert_zero_stuff_R2: assert property (@(posedge clk) disable iff (rst)
        (is_interp && !ph.accept) |=> (tap0 == '0));

    // without a sync fall, accept edges and zero edges alternate
    assert_phase_alternates_R2: assert property (@(posedge clk) disable iff (rst)
        (live_q && !(($past(sync_i)) && !sync_i)) |-> (ph.accept != $past(ph.accept)));

    // a sync fall makes the current edge an accept edge
    assert_sync_realign_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sync_i) && !sync_i) |-> ph.accept);

    // decimation leaves the output untouched on accept edges
    assert_decim_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (is_decim && ph.accept) |=> $stable(dout_o));

endmodule

// File: tb/hbf_filter_bench.sv
module hbf_filter_bench;

    localparam int IN_W  = 12;
    localparam int OUT_W = 30;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [1:0]              mode_i = 2'd0;
    logic                    half_gain_i = 1'b0;
    logic                    dbl_lat_i = 1'b0;
    logic                    sync_i = 1'b0;
    logic signed [IN_W-1:0]  din_i = '0;
    logic signed [OUT_W-1:0] dout_o;

    hbf_filter u_hbf_filter (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_i),
        .half_gain_i (half_gain_i),
        .dbl_lat_i   (dbl_lat_i),
        .sync_i      (sync_i),
        .din_i       (din_i),
        .dout_o      (dout_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;

    // reference model state
    int hist [256];
    int k;
    int expv;
    bit prev_sync;
    bit last_acc;

    function automatic int coef_at(input int j);
        int off;
        int a;
        off = j - 19;
        a   = (off < 0) ? -off : off;
        if (a == 0) return 16384;
        if (a % 2 == 0) return 0;
        case (a)
            1:  return 10346;
            3:  return -3240;
            5:  return 1720;
            7:  return -1030;
            9:  return 640;
            11: return -390;
            13: return 230;
            15: return -120;
            17: return 60;
            default: return -24;
        endcase
    endfunction

    function automatic int samp(input int i);
        return (i < 0) ? 0 : hist[i & 255];
    endfunction

    function automatic int base_at(input int m);
        int acc;
        if (mode_i == 2'd3) return samp(m - 34) * 32768;
        acc = 0;
        for (int j = 0; j < 39; j++) acc += coef_at(j) * samp(m - 15 - j);
        return acc;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic do_reset(input int md, input bit hg, input bit dl);
        rst = 1'b1;
        sync_i = 1'b0;
        din_i = '0;
        mode_i = md[1:0];
        half_gain_i = hg;
        dbl_lat_i = dl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) hist[i] = 0;
        k = 0;
        expv = 0;
        prev_sync = 1'b0;
        last_acc = 1'b1;
        chk(dout_o == '0, "R10 reset clears output", int'(dout_o), 0);
    endtask

    // drive one edge at a negedge, then check after the edge
    task automatic step(input int d, input bit s, input string req);
        bit acc_e;
        int smp;
        int v;
        bit interp;
        bit decim;
        interp = (mode_i == 2'd2);
        decim  = (mode_i == 2'd1);
        din_i  = d[IN_W-1:0];
        sync_i = s;
        acc_e  = (prev_sync && !s) ? 1'b1 : !last_acc;
        last_acc  = acc_e;
        prev_sync = s;
        smp = (interp && !acc_e) ? 0 : d;
        hist[k & 255] = smp;
        v = (dbl_lat_i && (interp || decim)) ? base_at(k - 34) : base_at(k);
        if (interp && !half_gain_i) v = v * 2;
        if (!(decim && acc_e)) expv = v;
        k++;
        @(negedge clk);
        chk(int'(dout_o) == expv, req, int'(dout_o), expv);
    endtask

    function automatic int rnd12();
        return int'($urandom_range(4095)) - 2048;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // equal-rate impulse: timing and kernel values
        do_reset(0, 0, 0);
        step(1000, 0, "R6 R7 R1 equal impulse");
        for (int i = 1; i <= 70; i++) begin
            step(0, 0, "R7 equal impulse tail");
            if (i == 14) chk(dout_o == 0, "R6 nothing before 15", int'(dout_o), 0);
            if (i == 15) chk(int'(dout_o) == -24000, "R6 first tap at 15", int'(dout_o), -24000);
            if (i == 34) chk(int'(dout_o) == 16384000, "R6 peak at 34", int'(dout_o), 16384000);
            if (i == 53) chk(int'(dout_o) == -24000, "R6 last tap at 53", int'(dout_o), -24000);
            if (i == 54) chk(dout_o == 0, "R6 zero after 53", int'(dout_o), 0);
        end

        // equal-rate DC at negative full scale
        do_reset(0, 0, 0);
        for (int i = 0; i < 90; i++) step(-2048, 0, "R11 equal DC");
        chk(int'(dout_o) == -2048 * 32768, "R11 equal unity gain", int'(dout_o), -2048 * 32768);

        // equal-rate random data, random strobe, double latency set
        do_reset(0, 0, 1);
        for (int i = 0; i < 150; i++) step(rnd12(), bit'($urandom_range(1)), "R5 R9 equal ignores sync and dbl");

        // delay-only with random strobe and double latency set
        do_reset(3, 0, 1);
        for (int i = 0; i < 120; i++) step(rnd12(), bit'($urandom_range(1)), "R8 R9 bypass delay");

        // interpolate 0 dB: sync pulse then random data, then DC
        do_reset(2, 0, 0);
        step(0, 1, "R3 interp sync high");
        for (int i = 0; i < 120; i++) step(rnd12(), 1'b0, "R2 R3 interp random");
        for (int i = 0; i < 100; i++) step(2047, 1'b0, "R2 interp DC");
        chk(int'(dout_o) == 2047 * 32768, "R11 interp unity gain", int'(dout_o), 2047 * 32768);

        // interpolate -6 dB DC, strobe toggling at half clock rate
        do_reset(2, 1, 0);
        for (int i = 0; i < 100; i++) step(1000, bit'(i % 2 == 0), "R11 interp half DC");
        chk(int'(dout_o) == 1000 * 16384, "R11 interp half gain", int'(dout_o), 1000 * 16384);

        // decimate with sync pulse, random data, mid-run realignment
        do_reset(1, 0, 0);
        step(0, 1, "R3 decim sync high");
        for (int i = 0; i < 80; i++) step(rnd12(), 1'b0, "R4 decim random");
        step(rnd12(), 1'b1, "R3 decim resync high");
        step(rnd12(), 1'b1, "R3 decim resync high");
        for (int i = 0; i < 80; i++) step(rnd12(), 1'b0, "R3 R4 decim after resync");

        // decimate with sync tied low
        do_reset(1, 0, 0);
        for (int i = 0; i < 100; i++) step(rnd12(), 1'b0, "R3 R4 decim sync low");

        // double-latency interpolate impulse: peak at 68 (doubled)
        do_reset(2, 0, 1);
        step(0, 1, "R9 interp dbl sync");
        step(500, 0, "R9 interp dbl impulse");
        for (int i = 1; i <= 100; i++) begin
            step(0, 0, "R9 interp dbl tail");
            if (i == 68) chk(int'(dout_o) == 500 * 16384 * 2, "R9 interp peak at 68",
                             int'(dout_o), 500 * 16384 * 2);
        end

        // double-latency decimate random
        do_reset(1, 0, 1);
        step(0, 1, "R9 decim dbl sync");
        for (int i = 0; i < 130; i++) step(rnd12(), 1'b0, "R9 decim dbl random");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule